// File: doc/BRIEF.md
# Debug Watchpoint Comparator Unit

This block watches a processor's memory bus and decides when the core must stop and enter debug state. It contains two match units, and software programs each one as either an instruction breakpoint or a data-access watchpoint. A unit compares its programmed address, data and control values with the live bus. Each compared bit has a mask bit, and a mask bit of 1 makes that bit don't care. A watchpoint fires on a completed data access. A breakpoint tags the matching fetch and carries that tag down a small pipeline model. It fires only if the tagged instruction reaches execute.

An external debug request can also force a halt. Once the halt is raised it stays high until a restart pulse. While halted, the cycle type passed on to the memory system is forced to "internal". A sticky status register records each cause that raised a halt: unit 0, unit 1 or the external request. All registers sit behind a simple parallel register port that stands in for the test access port.

Top module: `halt_match_unit`

## Requirements
- R1: After reset, halt_o is low, the status register reads 0 and every unit register reads 0, so both units are disabled.
- R2: An enabled watchpoint matches a completed data access (bus_valid_i=1, bus_fetch_i=0) when address, data and control equal the programmed values on every bit whose mask bit is 0. halt_o rises on the cycle after the access.
- R3: A unit whose enable bit is 0 never matches, whatever the bus carries.
- R4: A watchpoint ignores fetch accesses. A breakpoint ignores data accesses.
- R5: A breakpoint match at fetch raises halt_o only on the cycle after that instruction's exec_i pulse. Fetches pop out of the pipeline in fetch order. A flush_i before execute discards the tag, so no halt follows.
- R6: ext_req_i high while not halted raises halt_o on the next cycle and sets status bit 2.
- R7: Status bit 0 (unit 0 hit), bit 1 (unit 1 hit) and bit 2 (external) are sticky at address 16. Writing 1 to a bit clears only that bit.
- R8: halt_o stays high until restart_i. It is low on the cycle after restart_i.
- R9: While halt_o is high, cyc_type_o is 2'b00 (internal). Otherwise cyc_type_o equals cyc_type_i.
- R10: Unit u registers sit at address u*8 + {0: address value, 1: address mask, 2: data value, 3: data mask, 4: control}. The control word holds [3:0] control value, [7:4] control mask, [8] kind (1 = breakpoint), [9] enable. All registers read back what was written.
- R11: While halted, no bus activity or request sets a new status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 5 | Register address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i |
| bus_valid_i | input | 1 | A bus access completes this cycle |
| bus_fetch_i | input | 1 | 1 = instruction fetch, 0 = data access |
| bus_addr_i | input | ADDR_W | Access address |
| bus_data_i | input | DATA_W | Access data |
| bus_ctrl_i | input | CTRL_W | Access control signals |
| exec_i | input | 1 | Oldest fetched instruction enters execute |
| flush_i | input | 1 | Fetched but unexecuted instructions are discarded |
| ext_req_i | input | 1 | External debug request |
| restart_i | input | 1 | Leave debug state |
| cyc_type_i | input | 2 | Cycle type from the core |
| cyc_type_o | output | 2 | Cycle type to memory, internal while halted |
| halt_o | output | 1 | Debug-state halt request |

## Verification
The hardest case to reach from the ports is a breakpoint whose tagged fetch sits behind another fetch in the pipeline. It must fire only on the second execute pulse, and it must vanish when a flush arrives first. The stimulus drives fetch, exec and flush pulses in controlled orders for this. The compare logic gets near-exhaustive sweeps: all 256 pairs of control mask and control value, plus single-bit flips on every address and data bit with the mask bit on and off. Each of these sweeps is followed by restart and a status clear.

// File: rtl/wpu_pkg.sv
package wpu_pkg;
  localparam int NUM_UNITS   = 2;
  localparam int REG_W       = 32;
  localparam int RADDR_W     = 5;
  localparam int UNIT_STRIDE = 8;
  localparam int OFF_AVAL    = 0;
  localparam int OFF_AMSK    = 1;
  localparam int OFF_DVAL    = 2;
  localparam int OFF_DMSK    = 3;
  localparam int OFF_CTRL    = 4;
  localparam logic [RADDR_W-1:0] STATUS_ADDR = 5'd16;
  localparam logic [1:0] CYC_INTERNAL = 2'b00;
endpackage

// File: rtl/wpu_regs.sv
module wpu_regs
  import wpu_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int CTRL_W = 4
) (
  input  logic                                clk_i,
  input  logic                                rst_ni,
  input  logic                                wr_i,
  input  logic [RADDR_W-1:0]                  addr_i,
  input  logic [REG_W-1:0]                    wdata_i,
  output logic [REG_W-1:0]                    rdata_o,
  output logic [NUM_UNITS-1:0][ADDR_W-1:0]    aval_o,
  output logic [NUM_UNITS-1:0][ADDR_W-1:0]    amsk_o,
  output logic [NUM_UNITS-1:0][DATA_W-1:0]    dval_o,
  output logic [NUM_UNITS-1:0][DATA_W-1:0]    dmsk_o,
  output logic [NUM_UNITS-1:0][CTRL_W-1:0]    cval_o,
  output logic [NUM_UNITS-1:0][CTRL_W-1:0]    cmsk_o,
  output logic [NUM_UNITS-1:0]                kind_o,
  output logic [NUM_UNITS-1:0]                en_o
);
  localparam int OFF_W = $clog2(UNIT_STRIDE);
  localparam int SEL_W = RADDR_W - OFF_W;

  logic [SEL_W-1:0] sel;
  logic [OFF_W-1:0] off;
  assign sel = addr_i[RADDR_W-1:OFF_W];
  assign off = addr_i[OFF_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      aval_o <= '0; amsk_o <= '0; dval_o <= '0; dmsk_o <= '0;
      cval_o <= '0; cmsk_o <= '0; kind_o <= '0; en_o <= '0;
    end else if (wr_i) begin
      for (int u = 0; u < NUM_UNITS; u++) begin
        if (sel == SEL_W'(u)) begin
          case (off)
            OFF_W'(OFF_AVAL): aval_o[u] <= wdata_i[ADDR_W-1:0];
            OFF_W'(OFF_AMSK): amsk_o[u] <= wdata_i[ADDR_W-1:0];
            OFF_W'(OFF_DVAL): dval_o[u] <= wdata_i[DATA_W-1:0];
            OFF_W'(OFF_DMSK): dmsk_o[u] <= wdata_i[DATA_W-1:0];
            OFF_W'(OFF_CTRL): begin
              cval_o[u] <= wdata_i[CTRL_W-1:0];
              cmsk_o[u] <= wdata_i[2*CTRL_W-1:CTRL_W];
              kind_o[u] <= wdata_i[2*CTRL_W];
              en_o[u]   <= wdata_i[2*CTRL_W+1];
            end
            default: ;
          endcase
        end
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int u = 0; u < NUM_UNITS; u++) begin
      if (sel == SEL_W'(u)) begin
        case (off)
          OFF_W'(OFF_AVAL): rdata_o = REG_W'(aval_o[u]);
          OFF_W'(OFF_AMSK): rdata_o = REG_W'(amsk_o[u]);
          OFF_W'(OFF_DVAL): rdata_o = REG_W'(dval_o[u]);
          OFF_W'(OFF_DMSK): rdata_o = REG_W'(dmsk_o[u]);
          OFF_W'(OFF_CTRL): rdata_o = REG_W'({en_o[u], kind_o[u], cmsk_o[u], cval_o[u]});
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/wpu_cmp.sv
module wpu_cmp #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int CTRL_W = 4
) (
  input  logic              valid_i,
  input  logic              fetch_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [CTRL_W-1:0] ctrl_i,
  input  logic [ADDR_W-1:0] aval_i,
  input  logic [ADDR_W-1:0] amsk_i,
  input  logic [DATA_W-1:0] dval_i,
  input  logic [DATA_W-1:0] dmsk_i,
  input  logic [CTRL_W-1:0] cval_i,
  input  logic [CTRL_W-1:0] cmsk_i,
  input  logic              kind_i,
  input  logic              en_i,
  output logic              match_o
);
  logic a_ok, d_ok, c_ok, type_ok;
  assign a_ok    = ((addr_i ^ aval_i) & ~amsk_i) == '0;
  assign d_ok    = ((data_i ^ dval_i) & ~dmsk_i) == '0;
  assign c_ok    = ((ctrl_i ^ cval_i) & ~cmsk_i) == '0;
  // breakpoints look at fetches, watchpoints at data accesses
  assign type_ok = (kind_i == fetch_i);
  assign match_o = en_i & valid_i & type_ok & a_ok & d_ok & c_ok;
endmodule

// File: rtl/wpu_tag_pipe.sv
module wpu_tag_pipe #(
  parameter int DEPTH = 2,
  parameter int TAG_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             push_i,
  input  logic [TAG_W-1:0] tag_i,
  input  logic             pop_i,
  output logic [TAG_W-1:0] head_o
);
  localparam int CW = $clog2(DEPTH + 1);

  logic [DEPTH-1:0][TAG_W-1:0] q_q, q_d;
  logic [CW-1:0]               cnt_q, cnt_d;

  assign head_o = (cnt_q != '0) ? q_q[0] : '0;

  always_comb begin
    q_d   = q_q;
    cnt_d = cnt_q;
    if (pop_i && cnt_q != '0) begin
      for (int i = 0; i < DEPTH - 1; i++) q_d[i] = q_q[i+1];
      q_d[DEPTH-1] = '0;
      cnt_d = cnt_q - 1'b1;
    end
    if (push_i && cnt_d < CW'(DEPTH)) begin
      q_d[cnt_d] = tag_i;
      cnt_d = cnt_d + 1'b1;
    end
    if (clr_i) begin
      q_d   = '0;
      cnt_d = '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_q   <= '0;
      cnt_q <= '0;
    end else begin
      q_q   <= q_d;
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/halt_match_unit.sv
module halt_match_unit
  import wpu_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int CTRL_W     = 4,
  parameter int PIPE_DEPTH = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               reg_wr_i,
  input  logic [4:0]         reg_addr_i,
  input  logic [31:0]        reg_wdata_i,
  output logic [31:0]        reg_rdata_o,
  input  logic               bus_valid_i,
  input  logic               bus_fetch_i,
  input  logic [ADDR_W-1:0]  bus_addr_i,
  input  logic [DATA_W-1:0]  bus_data_i,
  input  logic [CTRL_W-1:0]  bus_ctrl_i,
  input  logic               exec_i,
  input  logic               flush_i,
  input  logic               ext_req_i,
  input  logic               restart_i,
  input  logic [1:0]         cyc_type_i,
  output logic [1:0]         cyc_type_o,
  output logic               halt_o
);
  localparam int ST_W = NUM_UNITS + 1;

  logic [NUM_UNITS-1:0][ADDR_W-1:0] aval, amsk;
  logic [NUM_UNITS-1:0][DATA_W-1:0] dval, dmsk;
  logic [NUM_UNITS-1:0][CTRL_W-1:0] cval, cmsk;
  logic [NUM_UNITS-1:0]             kind, en, match, bp_tag, wp_hit, bp_fire, unit_hit;
  logic [REG_W-1:0]                 unit_rdata;
  logic [ST_W-1:0]                  status_q, st_set, st_clr;
  logic                             halt_q, live, ext_hit, trig, st_sel;

  wpu_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTRL_W(CTRL_W)) i_regs (
    .clk_i, .rst_ni, .wr_i(reg_wr_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .rdata_o(unit_rdata), .aval_o(aval), .amsk_o(amsk), .dval_o(dval), .dmsk_o(dmsk),
    .cval_o(cval), .cmsk_o(cmsk), .kind_o(kind), .en_o(en)
  );

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
    wpu_cmp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTRL_W(CTRL_W)) i_cmp (
      .valid_i(bus_valid_i), .fetch_i(bus_fetch_i), .addr_i(bus_addr_i),
      .data_i(bus_data_i), .ctrl_i(bus_ctrl_i), .aval_i(aval[u]), .amsk_i(amsk[u]),
      .dval_i(dval[u]), .dmsk_i(dmsk[u]), .cval_i(cval[u]), .cmsk_i(cmsk[u]),
      .kind_i(kind[u]), .en_i(en[u]), .match_o(match[u])
    );
  end

  assign live   = !halt_q && !restart_i;
  assign wp_hit = match & ~kind;

  wpu_tag_pipe #(.DEPTH(PIPE_DEPTH), .TAG_W(NUM_UNITS)) i_pipe (
    .clk_i, .rst_ni, .clr_i(flush_i | restart_i),
    .push_i(bus_valid_i & bus_fetch_i & !halt_q), .tag_i(match & kind),
    .pop_i(exec_i), .head_o(bp_tag)
  );

  assign bp_fire  = bp_tag & {NUM_UNITS{exec_i}};
  assign unit_hit = (wp_hit | bp_fire) & {NUM_UNITS{live}};
  assign ext_hit  = ext_req_i & live;
  assign trig     = (|unit_hit) | ext_hit;

  assign st_sel = reg_wr_i && (reg_addr_i == STATUS_ADDR);
  assign st_clr = st_sel ? reg_wdata_i[ST_W-1:0] : '0;
  assign st_set = {ext_hit, unit_hit};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      halt_q   <= 1'b0;
      status_q <= '0;
    end else begin
      halt_q   <= restart_i ? 1'b0 : (halt_q | trig);
      status_q <= (status_q & ~st_clr) | st_set;
    end
  end

  assign halt_o      = halt_q;
  assign cyc_type_o  = halt_q ? CYC_INTERNAL : cyc_type_i;
  assign reg_rdata_o = (reg_addr_i == STATUS_ADDR) ? REG_W'(status_q) : unit_rdata;
endmodule

// File: rtl/wpu_checker.sv
module wpu_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       halt_o,
  input logic       restart_i,
  input logic       ext_req_i,
  input logic [1:0] cyc_type_i,
  input logic [1:0] cyc_type_o,
  input logic       reg_wr_i,
  input logic [4:0] reg_addr_i,
  input logic [2:0] status_q
);
  a_r8_halt_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_o && !restart_i |=> halt_o);
  a_r8_restart_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> !halt_o);
  a_r9_internal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_o |-> cyc_type_o == 2'b00);
  a_r9_pass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !halt_o |-> cyc_type_o == cyc_type_i);
  a_r6_ext_halts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_req_i && !halt_o && !restart_i |=> halt_o && status_q[2]);
  a_r7_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(reg_wr_i && reg_addr_i == 5'd16) |=> (status_q & $past(status_q)) == $past(status_q));
  a_r11_no_new_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_o |=> (status_q & ~$past(status_q)) == 3'b000);
endmodule

bind halt_match_unit wpu_checker i_wpu_checker (
  .clk_i(clk_i), .rst_ni(rst_ni), .halt_o(halt_o), .restart_i(restart_i),
  .ext_req_i(ext_req_i), .cyc_type_i(cyc_type_i), .cyc_type_o(cyc_type_o),
  .reg_wr_i(reg_wr_i), .reg_addr_i(reg_addr_i), .status_q(status_q)
);

// File: tb/test_halt_match_unit.sv
module test_halt_match_unit;
  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        reg_wr_i = 0;
  logic [4:0]  reg_addr_i = 0;
  logic [31:0] reg_wdata_i = 0, reg_rdata_o;
  logic        bus_valid_i = 0, bus_fetch_i = 0;
  logic [31:0] bus_addr_i = 0, bus_data_i = 0;
  logic [3:0]  bus_ctrl_i = 0;
  logic        exec_i = 0, flush_i = 0, ext_req_i = 0, restart_i = 0;
  logic [1:0]  cyc_type_i = 2'b11, cyc_type_o;
  logic        halt_o;
  int checks = 0, errors = 0;

  always #10 clk_i = ~clk_i;

  halt_match_unit i_halt_match_unit (.*);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d);
    reg_wr_i = 1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk_i);
    reg_wr_i = 0;
  endtask

  task automatic rd(logic [4:0] a, output logic [31:0] d);
    reg_addr_i = a; #1; d = reg_rdata_o;
  endtask

  function automatic logic [31:0] cw(logic en, logic bp, logic [3:0] m, logic [3:0] v);
    return {22'd0, en, bp, m, v};
  endfunction

  task automatic access(logic f, logic [31:0] a, logic [31:0] d, logic [3:0] c);
    bus_valid_i = 1; bus_fetch_i = f; bus_addr_i = a; bus_data_i = d; bus_ctrl_i = c;
    @(negedge clk_i);
    bus_valid_i = 0;
  endtask

  task automatic pulse_exec(); exec_i = 1; @(negedge clk_i); exec_i = 0; endtask
  task automatic pulse_flush(); flush_i = 1; @(negedge clk_i); flush_i = 0; endtask

  task automatic recover();
    restart_i = 1; @(negedge clk_i); restart_i = 0;
    wr(5'd16, 32'h7);
  endtask

  // single watch access: check halt and status, then return to running
  task automatic probe(string req, logic f, logic [31:0] a, logic [31:0] d, logic [3:0] c,
                       logic exp_h, logic [31:0] exp_s);
    logic [31:0] s;
    access(f, a, d, c);
    check(req, {31'd0, halt_o}, {31'd0, exp_h});
    rd(5'd16, s);
    check(req, s, exp_s);
    recover();
    if (f) pulse_flush();
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    // R1 reset state
    check("R1 halt", {31'd0, halt_o}, 0);
    rd(5'd16, r); check("R1 status", r, 0);
    for (int u = 0; u < 2; u++)
      for (int o = 0; o < 5; o++) begin
        rd(5'(u * 8 + o), r); check("R1 regs", r, 0);
      end
    // R3 disabled unit ignores an all-zero match
    probe("R3 disabled", 0, 0, 0, 0, 0, 0);

    // R10 readback
    wr(5'd0, 32'h1234_5678); wr(5'd1, 32'h0); wr(5'd2, 32'hCAFE_0000);
    wr(5'd3, 32'h0); wr(5'd4, cw(1, 0, 4'h0, 4'hA));
    rd(5'd0, r); check("R10 aval", r, 32'h1234_5678);
    rd(5'd2, r); check("R10 dval", r, 32'hCAFE_0000);
    rd(5'd4, r); check("R10 ctrl", r, cw(1, 0, 4'h0, 4'hA));
    wr(5'd9, 32'h00FF_00FF); rd(5'd9, r); check("R10 u1 amsk", r, 32'h00FF_00FF);
    wr(5'd9, 32'h0);

    // R2 control sweep: every mask against every value
    for (int m = 0; m < 16; m++) begin
      wr(5'd4, cw(1, 0, 4'(m), 4'hA));
      for (int c = 0; c < 16; c++) begin
        logic e;
        e = (((4'(c) ^ 4'hA) & ~4'(m)) == 4'h0);
        probe("R2 ctrl", 0, 32'h1234_5678, 32'hCAFE_0000, 4'(c), e, {31'd0, e});
      end
    end
    // R2 address and data single-bit flips with mask on and off
    wr(5'd4, cw(1, 0, 4'hF, 4'h0));
    for (int b = 0; b < 32; b++) begin
      wr(5'd1, 32'h0);
      probe("R2 addr nomask", 0, 32'h1234_5678 ^ (32'h1 << b), 32'hCAFE_0000, 0, 0, 0);
      wr(5'd1, 32'h1 << b);
      probe("R2 addr mask", 0, 32'h1234_5678 ^ (32'h1 << b), 32'hCAFE_0000, 0, 1, 1);
    end
    wr(5'd1, 32'h0);
    for (int b = 0; b < 32; b++) begin
      wr(5'd3, 32'h0);
      probe("R2 data nomask", 0, 32'h1234_5678, 32'hCAFE_0000 ^ (32'h1 << b), 0, 0, 0);
      wr(5'd3, 32'h1 << b);
      probe("R2 data mask", 0, 32'h1234_5678, 32'hCAFE_0000 ^ (32'h1 << b), 0, 1, 1);
    end
    wr(5'd3, 32'h0);
    // R4 watchpoint ignores a fetch
    probe("R4 wp fetch", 1, 32'h1234_5678, 32'hCAFE_0000, 0, 0, 0);
    // R3 disable unit 0
    wr(5'd4, cw(0, 0, 4'hF, 4'h0));
    probe("R3 off", 0, 32'h1234_5678, 32'hCAFE_0000, 0, 0, 0);

    // unit 1 breakpoint at 0x200, data don't care
    wr(5'd8, 32'h200); wr(5'd9, 0); wr(5'd11, 32'hFFFF_FFFF); wr(5'd12, cw(1, 1, 4'hF, 4'h0));
    // R4 breakpoint ignores data accesses
    probe("R4 bp data", 0, 32'h200, 0, 0, 0, 0);
    // R5 tagged fetch behind an older one
    access(1, 32'h1FC, 0, 0);
    access(1, 32'h200, 0, 0);
    check("R5 no halt at fetch", {31'd0, halt_o}, 0);
    pulse_exec();
    check("R5 older exec", {31'd0, halt_o}, 0);
    pulse_exec();
    check("R5 tagged exec", {31'd0, halt_o}, 1);
    rd(5'd16, r); check("R5 status", r, 32'h2);
    // R9 cycle type forced internal while halted
    check("R9 halted", {30'd0, cyc_type_o}, 0);
    // R8 halt holds without restart
    repeat (3) @(negedge clk_i);
    check("R8 hold", {31'd0, halt_o}, 1);
    recover();
    check("R8 released", {31'd0, halt_o}, 0);
    check("R9 running", {30'd0, cyc_type_o}, 32'h3);
    // R5 flush discards tag
    access(1, 32'h200, 0, 0);
    pulse_flush();
    pulse_exec();
    check("R5 flushed", {31'd0, halt_o}, 0);

    // R6 external request
    ext_req_i = 1; @(negedge clk_i); ext_req_i = 0;
    check("R6 halt", {31'd0, halt_o}, 1);
    rd(5'd16, r); check("R6 status", r, 32'h4);
    // R11 activity while halted sets nothing new
    wr(5'd4, cw(1, 0, 4'hF, 4'h0));
    access(0, 32'h1234_5678, 32'hCAFE_0000, 0);
    ext_req_i = 1; @(negedge clk_i); ext_req_i = 0;
    rd(5'd16, r); check("R11 status", r, 32'h4);
    restart_i = 1; @(negedge clk_i); restart_i = 0;
    // R7 sticky and write-one-to-clear per bit
    access(0, 32'h1234_5678, 32'hCAFE_0000, 0);
    rd(5'd16, r); check("R7 two bits", r, 32'h5);
    restart_i = 1; @(negedge clk_i); restart_i = 0;
    repeat (2) @(negedge clk_i);
    rd(5'd16, r); check("R7 sticky", r, 32'h5);
    wr(5'd16, 32'h1);
    rd(5'd16, r); check("R7 clear bit0", r, 32'h4);
    wr(5'd16, 32'h4);
    rd(5'd16, r); check("R7 clear bit2", r, 32'h0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule